// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block behaves as a byte-wide serial EEPROM on a two-wire bus. The bus clock and data lines are sampled with the system clock and pass through two-flop synchronizers. Bus start and stop conditions are recognised from the synchronized levels, and a byte-level state machine drives the data line through a separate pull-low enable, since the line is open-drain. A device-select byte opens every transaction. An optional word-address byte follows it. The slave then either takes data bytes into a page buffer or sends bytes from an internal array while incrementing an address counter.

Writes are staged in a 16-entry page buffer. Only a stop condition that follows an acknowledged data byte commits them. That stop starts a timed write cycle. For its whole length the slave ignores the bus and copies the staged bytes into the array. Three chip-enable pins set the bus address. At larger capacities the matching select bits act as high memory-address bits instead. A write-lock input blocks storage and removes the data-byte acknowledges.

States: `S_IDLE` waits for a start. `S_DEV`, `S_ADR` and `S_WR` shift in a select, address or data byte. `S_DEV_ACK`, `S_ADR_ACK` and `S_WR_ACK` hold the ninth clock. `S_RD` shifts out a byte. `S_RD_ACK` samples the master's acknowledge. `S_BUSY` runs the write cycle.

Transitions:
- A start moves any state except `S_BUSY` to `S_DEV`.
- A stop moves to `S_BUSY` if data is pending and to `S_IDLE` otherwise.
- After eight bits, each receive state moves to its ack state. The one exception is a non-matching select, which returns to `S_IDLE`.
- From `S_DEV_ACK` the next state is `S_RD` or `S_ADR`, chosen by the read/write bit.
- `S_ADR_ACK` and `S_WR_ACK` go on to `S_WR`.
- `S_RD` goes to `S_RD_ACK`.
- `S_RD_ACK` goes back to `S_RD` on an acknowledge and to `S_IDLE` on a no-acknowledge.
- `S_BUSY` goes to `S_IDLE` when the timer expires.

Top module: `eeprom_slave`

## Requirements
- R1: A start is the data line falling while the clock is high, and a stop is the data line rising while the clock is high. After reset, and after any finished transaction, bytes clocked without a start get no acknowledge.
- R2: The select byte is shifted in MSB first and acknowledged by pulling data low during the 9th clock. The acknowledge is given only when bits 7..4 equal 1010 and every chip-enable compare still in use matches its pin. Bit 0 set to 1 means read. The slave changes its drive only while the clock is low.
- R3: When the capacity is 2^(8+k) bytes, select bits b1..b(k) carry address bits A8 upward and are not compared with the chip-enable pins. With 512 bytes, b1 is A8 and chip-enable pin 0 is ignored.
- R4: A byte write is a write select, an address byte, a data byte and a stop. All three bytes are acknowledged, and the byte is stored at that address.
- R5: Within one write, each data byte goes to the next address. Only the low 4 address bits count, wrapping within the 16-byte page. More than 16 bytes overwrite the earliest ones.
- R6: With write-lock high, the select and address bytes are acknowledged, but data bytes get no acknowledge and are not stored.
- R7: Data bytes are committed only by a stop. A repeated start after data discards them and starts no write cycle.
- R8: A committing stop starts a write cycle of WR_CYCLES clocks. During that cycle every start and select is ignored. After it the slave answers again.
- R9: A random read is a write select, an address byte, a repeated start and a read select. Each master acknowledge yields the byte at the next address, and the address wraps from the top of the array to 0.
- R10: The address counter persists across transactions. A current-address read uses it, with its high bits taken from the read select.
- R11: A master no-acknowledge ends the read. Clocks that follow without a start find the data line released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_en_i | input | 3 | Chip-enable pins compared against select bits 3..1 |
| wr_lock_i | input | 1 | Write lock: data bytes refused when high |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data line |

## Verification
Most internal faults show up within one byte time. A mis-set bit counter or a wrong select compare moves or removes the ninth-clock acknowledge, and the master reads that pulse directly. A fault in the address counter or page index appears as wrong data on the next read-back, after the write cycle. A fault in the busy timer shows up as an acknowledge given during a write cycle, or as one still refused after it.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_DEV, S_DEV_ACK, S_ADR, S_ADR_ACK,
        S_WR, S_WR_ACK, S_RD, S_RD_ACK, S_BUSY
    } eep_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_ff, sda_ff;
    logic       scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_q  <= scl_ff[1];
            sda_q  <= sda_ff[1];
        end
    end

    assign scl_s    = scl_ff[1];
    assign sda_s    = sda_ff[1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES = 400,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              copy_en,
    output logic [PAGE_W-1:0] idx
);
    localparam int CW   = $clog2(CYCLES + 1);
    localparam int PAGE = 1 << PAGE_W;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CW'(CYCLES - 1)) busy <= 1'b0;
            cnt <= cnt + CW'(1);
        end
    end

    assign copy_en = busy && (cnt < CW'(PAGE));
    assign idx     = cnt[PAGE_W-1:0];
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [PAGE_W-1:0] wi,
    input  logic [7:0]        wd,
    input  logic [PAGE_W-1:0] ri,
    output logic [7:0]        rd,
    output logic              rv
);
    localparam int PAGE = 1 << PAGE_W;

    logic [7:0]      slot [PAGE];
    logic [PAGE-1:0] vld;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld <= '0;
        else if (clr) vld <= '0;
        else if (we)  vld[wi] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (we) slot[wi] <= wd;
    end

    assign rd = slot[ri];
    assign rv = vld[ri];
endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [7:0]    wd,
    input  logic [AW-1:0] ra,
    output logic [7:0]    rd
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign rd = mem[ra];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] chip_en_i,
    input  logic       wr_lock_i,
    output logic       sda_pull_o
);
    localparam int         HI      = ADDR_W - 8;
    localparam logic [2:0] CE_MASK = 3'(3'b111 << HI);

    eep_state_e        state, nxt;
    logic              sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic [3:0]        bitc;
    logic [7:0]        sh, obyte, buf_d, mem_rd;
    logic              rw_q, pend, mack, pull_q;
    logic [2:0]        sel_hi_q, sel_hi;
    logic [ADDR_W-1:0] addr;
    logic              busy, copy_en, go, buf_we, buf_v, mem_we;
    logic [PAGE_W-1:0] cidx;
    logic              sel_ok, byte_end, rx_state;

    assign byte_end   = scl_fall && (bitc == 4'd8);
    assign sel_ok     = (sh[7:4] == DEV_TYPE) && (((sh[3:1] ^ chip_en_i) & CE_MASK) == 3'b000);
    assign sel_hi     = sh[3:1] & ~CE_MASK;
    assign go         = (state != S_BUSY) && (nxt == S_BUSY);
    assign buf_we     = (state == S_WR) && byte_end && !wr_lock_i;
    assign mem_we     = copy_en && buf_v;
    assign rx_state   = (state == S_DEV) || (state == S_ADR) || (state == S_WR);
    assign sda_pull_o = pull_q;

    eep_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    eep_wr_timer #(.CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .copy_en(copy_en), .idx(cidx)
    );

    eep_page_buf #(.PAGE_W(PAGE_W)) u_page (
        .clk(clk), .rst_n(rst_n), .clr(start_ev && (state != S_BUSY)), .we(buf_we),
        .wi(addr[PAGE_W-1:0]), .wd(sh), .ri(cidx), .rd(buf_d), .rv(buf_v)
    );

    eep_store #(.AW(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .wa({addr[ADDR_W-1:PAGE_W], cidx}),
        .wd(buf_d), .ra(addr), .rd(mem_rd)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (state == S_BUSY) begin
            if (!busy) nxt = S_IDLE;
        end else if (start_ev) begin
            nxt = S_DEV;
        end else if (stop_ev) begin
            nxt = pend ? S_BUSY : S_IDLE;
        end else begin
            unique case (state)
                S_DEV:     if (byte_end) nxt = sel_ok ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK: if (scl_fall) nxt = rw_q ? S_RD : S_ADR;
                S_ADR:     if (byte_end) nxt = S_ADR_ACK;
                S_ADR_ACK: if (scl_fall) nxt = S_WR;
                S_WR:      if (byte_end) nxt = S_WR_ACK;
                S_WR_ACK:  if (scl_fall) nxt = S_WR;
                S_RD:      if (byte_end) nxt = S_RD_ACK;
                S_RD_ACK:  if (scl_fall) nxt = mack ? S_RD : S_IDLE;
                default:   nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and line drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitc <= '0; sh <= '0; obyte <= '0; rw_q <= 1'b0; pend <= 1'b0;
            mack <= 1'b0; pull_q <= 1'b0; sel_hi_q <= '0; addr <= '0;
        end else if (state == S_BUSY) begin
            pull_q <= 1'b0;
        end else if (start_ev) begin
            bitc <= '0; pend <= 1'b0; pull_q <= 1'b0;
        end else if (stop_ev) begin
            pull_q <= 1'b0;
        end else if (rx_state && scl_rise) begin
            sh   <= {sh[6:0], sda_s};
            bitc <= bitc + 4'd1;
        end else begin
            unique case (state)
                S_DEV: if (byte_end) begin
                    bitc     <= '0;
                    rw_q     <= sh[0];
                    sel_hi_q <= sel_hi;
                    pull_q   <= sel_ok;
                    if (sel_ok && sh[0]) addr <= ADDR_W'({sel_hi, addr[7:0]});
                end
                S_ADR: if (byte_end) begin
                    bitc   <= '0;
                    pull_q <= 1'b1;
                    addr   <= ADDR_W'({sel_hi_q, sh});
                end
                S_WR: if (byte_end) begin
                    bitc <= '0;
                    if (!wr_lock_i) begin
                        pull_q <= 1'b1;
                        pend   <= 1'b1;
                        addr   <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};
                    end
                end
                S_DEV_ACK, S_RD_ACK: begin
                    if (state == S_RD_ACK && scl_rise) mack <= ~sda_s;
                    if (scl_fall) begin
                        if ((state == S_DEV_ACK && rw_q) || (state == S_RD_ACK && mack)) begin
                            obyte  <= mem_rd;
                            pull_q <= ~mem_rd[7];
                            addr   <= addr + ADDR_W'(1);
                            bitc   <= '0;
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                S_ADR_ACK, S_WR_ACK: if (scl_fall) pull_q <= 1'b0;
                S_RD: begin
                    if (scl_rise) bitc <= bitc + 4'd1;
                    else if (scl_fall) begin
                        if (bitc == 4'd8) pull_q <= 1'b0;
                        else begin
                            obyte  <= {obyte[6:0], 1'b0};
                            pull_q <= ~obyte[6];
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_slave_chk.sv
module eeprom_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull_o,
    input logic busy,
    input logic mem_we,
    input logic stop_ev,
    input logic in_idle
);
    // R8: no drive while a write cycle runs
    a_r8_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R4: the array changes only inside the write cycle
    a_r4_store_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R7: a write cycle starts only from a stop condition
    a_r7_cycle_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev));

    // R11: line released whenever the slave is idle
    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_pull_o);
endmodule

bind eeprom_slave eeprom_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull_o(sda_pull_o), .busy(busy),
    .mem_we(mem_we), .stop_ev(stop_ev), .in_idle(state == eep_pkg::S_IDLE)
);

// File: tb/eeprom_slave_test.sv
module eeprom_slave_test;
    localparam int WR = 400;
    localparam int Q  = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [2:0] ce = 3'b101;
    logic lock = 1'b0;
    logic pull;
    wire  line = sda_m & ~pull;

    int n_chk = 0, n_err = 0;
    logic [7:0] ref_m [512];
    logic [7:0] wbuf  [32];

    always #4 clk = ~clk;

    eeprom_slave #(.ADDR_W(9), .PAGE_W(4), .WR_CYCLES(WR)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line),
        .chip_en_i(ce), .wr_lock_i(lock), .sda_pull_o(pull)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask
    task automatic bstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
    task automatic bstop();  sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask

    task automatic tx(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1; wq(); scl_m = 0; wq();
        end
        sda_m = 1; wq(); scl_m = 1; wq(); ack = !line; scl_m = 0; wq();
    endtask

    task automatic rx(input bit give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1; wq(); b = {b[6:0], line}; scl_m = 0;
        end
        wq(); sda_m = !give_ack; wq(); scl_m = 1; wq(); scl_m = 0; wq(); sda_m = 1;
    endtask

    function automatic logic [7:0] dsel(input bit a8, input bit rd);
        return {4'hA, 2'b10, a8, rd};
    endfunction

    task automatic wr_bytes(input logic [8:0] a, input int n, input bit wait_done);
        bit k;
        bstart(); tx(dsel(a[8], 0), k); chk("R2 select ack", int'(k), 1);
        tx(a[7:0], k); chk("R4 address ack", int'(k), 1);
        for (int j = 0; j < n; j++) begin
            tx(wbuf[j], k); chk("R4 data ack", int'(k), 1);
            ref_m[{a[8:4], a[3:0] + 4'(j)}] = wbuf[j];
        end
        bstop();
        if (wait_done) repeat (WR + 40) @(negedge clk);
    endtask

    task automatic rd_seq(input logic [8:0] a, input int n, input string tag);
        bit k; logic [7:0] b;
        bstart(); tx(dsel(a[8], 0), k); tx(a[7:0], k);
        bstart(); tx(dsel(a[8], 1), k); chk("R9 read select ack", int'(k), 1);
        for (int j = 0; j < n; j++) begin
            rx(j < n - 1, b); chk(tag, int'(b), int'(ref_m[9'(a + 9'(j))]));
        end
        bstop();
    endtask

    task automatic rd_cur(input bit a8, input int exp, input string tag);
        bit k; logic [7:0] b;
        bstart(); tx(dsel(a8, 1), k); chk("R10 current select ack", int'(k), 1);
        rx(0, b); chk(tag, int'(b), exp); bstop();
    endtask

    initial begin
        repeat (2000) @(negedge clk);
        forever begin
            @(negedge clk);
            if (n_chk > 1000000) break;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        bit k; logic [7:0] b;
        for (int i = 0; i < 512; i++) ref_m[i] = 8'hFF;
        repeat (5) @(negedge clk);
        chk("R1 reset line released", int'(pull), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: byte with no start is ignored
        tx(8'hA8, k); chk("R1 no start no ack", int'(k), 0);
        bstop();

        // R2/R3 sweep: pins versus select bits; b1 is A8, pin 0 unused
        for (int p = 0; p < 8; p++) begin
            for (int c = 0; c < 8; c++) begin
                ce = 3'(p);
                bstart(); tx({4'hA, 3'(c), 1'b0}, k); bstop();
                chk("R3 select match sweep", int'(k), int'(c[2:1] == p[2:1]));
            end
            bstart(); tx({4'hB, 3'(p), 1'b0}, k); bstop();
            chk("R2 wrong type no ack", int'(k), 0);
        end
        ce = 3'b101;

        // R4 byte writes, both halves of A8
        wbuf[0] = 8'h5A; wr_bytes(9'h035, 1, 1);
        rd_seq(9'h035, 1, "R4 byte readback");
        wbuf[0] = 8'hC3; wr_bytes(9'h1C3, 1, 1);
        rd_seq(9'h1C3, 1, "R3 high address readback");

        // R8 busy window
        wbuf[0] = 8'h11; wr_bytes(9'h040, 1, 0);
        bstart(); tx(dsel(0, 0), k); bstop();
        chk("R8 select ignored while busy", int'(k), 0);
        repeat (WR + 40) @(negedge clk);
        rd_seq(9'h040, 1, "R8 answers after cycle");

        // R5 page write of 20 bytes from offset 3
        for (int j = 0; j < 20; j++) wbuf[j] = 8'(8'h30 + j);
        wr_bytes(9'h0A3, 20, 1);
        rd_seq(9'h09F, 18, "R5 page wrap contents");

        // R6 write lock
        lock = 1'b1;
        bstart(); tx(dsel(0, 0), k); chk("R6 select acked under lock", int'(k), 1);
        tx(8'h50, k); chk("R6 address acked under lock", int'(k), 1);
        tx(8'h77, k); chk("R6 data refused under lock", int'(k), 0);
        bstop(); repeat (WR + 40) @(negedge clk);
        lock = 1'b0;
        rd_seq(9'h050, 1, "R6 nothing stored");

        // R7 repeated start discards data
        bstart(); tx(dsel(0, 0), k); tx(8'h60, k); tx(8'h99, k);
        chk("R7 data acked before restart", int'(k), 1);
        bstart(); tx(dsel(0, 1), k); rx(0, b); bstop();
        chk("R7 read after restart", int'(b), int'(ref_m[9'h061]));
        bstart(); tx(dsel(0, 0), k); bstop();
        chk("R7 no write cycle started", int'(k), 1);
        rd_seq(9'h060, 1, "R7 data discarded");

        // R9 wrap at top of array
        wbuf[0] = 8'hEE; wr_bytes(9'h1FF, 1, 1);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wr_bytes(9'h000, 2, 1);
        rd_seq(9'h1FF, 2, "R9 sequential wrap");

        // R10 current address continues, high bit from select
        rd_cur(1'b0, 8'h02, "R10 current read follows");
        rd_seq(9'h0C2, 1, "R10 setup read");
        rd_cur(1'b1, 8'hC3, "R10 select high bit applied");

        // R11 no-ack ends read; later clocks see released line
        bstart(); tx(dsel(0, 1), k); rx(0, b); rx(0, b);
        chk("R11 line released after no-ack", int'(b), 8'hFF);
        bstop();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule